// File: doc/BRIEF.md
# Timeslot Interchange Switch with Idle Fill

This block exchanges byte-wide channels between an incoming and an outgoing time-division stream. Both streams share one frame-start pulse, at 8 kHz in the intended system. Each frame carries one byte per channel, and channel `n` occupies clock cycle `n` after the frame start. For every output channel, the host chooses either an input channel to copy or an idle byte of its own. The switch is non-blocking: every output can pick any input, and several outputs can pick the same input at once.

Incoming bytes are stored by slot into a two-bank data memory. One bank fills with the current frame while the other bank is read out with the previous frame, so every routed byte is delayed by exactly one frame.

Control settings sit in a two-bank control memory with one select bit per channel. A host write goes into the inactive copy of its entry and is switched in at the next frame start. The output stream and its frame-start pulse trail the input by a fixed three cycles. The channel count `NCH` is a parameter: the default is 256, and the design scales to 65536.

Top module: `tsi_switch`

## Requirements
- R1: After a synchronous reset, `out_data_o` equals `IDLE_DEF` (default 8'hFF) and `out_frame_start_o` is low. Any channel never written since reset is idle-filled with `IDLE_DEF`.
- R2: If output channel `n` is set to connect mode (`cfg_connect_i`=1) with source `s` (`cfg_src_i`), then output slot `n` of frame `k` carries the byte that arrived in input slot `s` of frame `k-1`.
- R3: Any number of output channels may name the same source in the same frame, and each of them receives that byte.
- R4: If output channel `n` is in idle mode (`cfg_connect_i`=0), output slot `n` carries the idle byte written with that entry (`cfg_idle_i`), whatever the input data is.
- R5: A control write sampled during a frame first affects the output frame built from the next frame start. The output slots of the frame in progress keep the previous setting.
- R6: A control write sampled on the same clock edge as an input frame start belongs to the new frame. It takes effect from the frame start after that one.
- R7: `out_frame_start_o` rises on the third rising edge counted from the edge that samples `frame_start_i`. Output slot `n` follows it by `n` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timeslot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | High in the cycle that carries input slot 0 |
| in_data_i | input | DW | Input byte of the current slot |
| cfg_we_i | input | 1 | Control entry write strobe |
| cfg_ch_i | input | clog2(NCH) | Output channel whose entry is written |
| cfg_connect_i | input | 1 | 1 = connect to a source, 0 = idle fill |
| cfg_src_i | input | clog2(NCH) | Source input channel for connect mode |
| cfg_idle_i | input | DW | Idle byte for this output channel |
| out_data_o | output | DW | Output byte of the current output slot |
| out_frame_start_o | output | 1 | High in the cycle that carries output slot 0 |

## Verification
The bench builds the switch with `NCH`=16, `DW`=8 and `IDLE_DEF`=8'hFF. At that size a frame lasts sixteen cycles, so the run can cover many whole frames and many complete connection maps: identity, reversal, heavy fan-out, mixed idle and random maps.

The short frame also lets the bench place a control write at exact slot positions. It issues one write just after a frame start and another on the frame-start edge itself. It then compares every output slot with a reference model that snapshots the configuration for each frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  // Registered stages between an input slot and the matching output slot
  localparam int unsigned TSI_PIPE_LAT = 3;

  typedef enum logic {
    MODE_IDLE    = 1'b0,
    MODE_CONNECT = 1'b1
  } tsi_mode_e;
endpackage

// File: rtl/tsi_slot_timer.sv
// Slot counter and data-bank selector, both locked to the frame-start pulse.
module tsi_slot_timer #(
  parameter  int NCH = 256,
  localparam int AW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start_i,
  output logic [AW-1:0] slot_o,
  output logic          wbank_o
);
  logic [AW-1:0] cnt_q;
  logic          bank_q;

  always_comb begin
    if (frame_start_i)                  slot_o = '0;
    else if (cnt_q == AW'(NCH - 1))     slot_o = '0;
    else                                slot_o = cnt_q + AW'(1);
    wbank_o = frame_start_i ? ~bank_q : bank_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= AW'(NCH - 1);
      bank_q <= 1'b0;
    end else begin
      cnt_q  <= slot_o;
      bank_q <= wbank_o;
    end
  end
endmodule

// File: rtl/tsi_ctrl_store.sv
// Two copies of every control entry plus a per-channel select bit.
// Host writes land in the inactive copy and are switched in at frame start.
module tsi_ctrl_store
  import tsi_pkg::*;
#(
  parameter  int            NCH      = 256,
  parameter  int            DW       = 8,
  parameter  logic [DW-1:0] IDLE_DEF = '1,
  localparam int            AW       = $clog2(NCH),
  localparam int            EW       = 1 + AW + DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start_i,
  input  logic [AW-1:0] rd_slot,
  input  logic          we,
  input  logic [AW-1:0] wr_ch,
  input  logic          wr_conn,
  input  logic [AW-1:0] wr_src,
  input  logic [DW-1:0] wr_idle,
  output logic          conn_o,
  output logic [AW-1:0] src_o,
  output logic [DW-1:0] idle_o
);
  logic [EW-1:0]  mem [2*NCH];
  logic [NCH-1:0] sel_q, pend_q, used_q;
  logic [NCH-1:0] sel_nx, pend_nx, used_nx;
  logic           wr_bank;
  logic [EW-1:0]  rd_raw;
  logic           used_rd;
  tsi_mode_e      rd_mode;

  always_comb begin
    sel_nx  = frame_start_i ? (sel_q ^ pend_q) : sel_q;
    used_nx = frame_start_i ? (used_q | pend_q) : used_q;
    pend_nx = frame_start_i ? '0 : pend_q;
    if (we) pend_nx[wr_ch] = 1'b1;
    wr_bank = ~sel_nx[wr_ch];
  end

  // Memory ports: one write, one registered read
  always_ff @(posedge clk) begin
    if (we) mem[{wr_bank, wr_ch}] <= {wr_conn, wr_src, wr_idle};
  end

  always_ff @(posedge clk) begin
    rd_raw <= mem[{sel_nx[rd_slot], rd_slot}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      pend_q  <= '0;
      used_q  <= '0;
      used_rd <= 1'b0;
    end else begin
      sel_q   <= sel_nx;
      pend_q  <= pend_nx;
      used_q  <= used_nx;
      used_rd <= used_nx[rd_slot];
    end
  end

  assign rd_mode = tsi_mode_e'(rd_raw[EW-1]);
  assign conn_o  = used_rd && (rd_mode == MODE_CONNECT);
  assign src_o   = rd_raw[DW +: AW];
  assign idle_o  = used_rd ? rd_raw[DW-1:0] : IDLE_DEF;
endmodule

// File: rtl/tsi_data_buf.sv
// Two-bank speech store: one bank fills while the other drains.
module tsi_data_buf #(
  parameter  int NCH = 256,
  parameter  int DW  = 8,
  localparam int AW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_slot,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_slot,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem [2*NCH];

  always_ff @(posedge clk) begin
    mem[{wr_bank, wr_slot}] <= wr_data;
  end

  // Read-before-write on a shared address keeps the older frame's byte
  always_ff @(posedge clk) begin
    rd_data_o <= mem[{rd_bank, rd_slot}];
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter  int            NCH      = 256,
  parameter  int            DW       = 8,
  parameter  logic [DW-1:0] IDLE_DEF = '1,
  localparam int            AW       = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          cfg_we_i,
  input  logic [AW-1:0] cfg_ch_i,
  input  logic          cfg_connect_i,
  input  logic [AW-1:0] cfg_src_i,
  input  logic [DW-1:0] cfg_idle_i,
  output logic [DW-1:0] out_data_o,
  output logic          out_frame_start_o
);
  localparam int LAT = TSI_PIPE_LAT;

  logic [AW-1:0] slot;
  logic          wbank;
  logic          ctl_conn;
  logic [AW-1:0] ctl_src;
  logic [DW-1:0] ctl_idle;
  logic          rbank_q;
  logic [DW-1:0] rd_q;
  logic          conn1_q;
  logic [DW-1:0] idle1_q;
  logic [LAT-1:0] fs_pipe_q;

  tsi_slot_timer #(.NCH(NCH)) u_timer (
    .clk           (clk),
    .rst           (rst),
    .frame_start_i (frame_start_i),
    .slot_o        (slot),
    .wbank_o       (wbank)
  );

  // Stage 0: look up the control entry of the slot being received
  tsi_ctrl_store #(.NCH(NCH), .DW(DW), .IDLE_DEF(IDLE_DEF)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .frame_start_i (frame_start_i),
    .rd_slot       (slot),
    .we            (cfg_we_i),
    .wr_ch         (cfg_ch_i),
    .wr_conn       (cfg_connect_i),
    .wr_src        (cfg_src_i),
    .wr_idle       (cfg_idle_i),
    .conn_o        (ctl_conn),
    .src_o         (ctl_src),
    .idle_o        (ctl_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) rbank_q <= 1'b0;
    else     rbank_q <= ~wbank;
  end

  // Stage 1: fetch the previous frame's byte from the source slot
  tsi_data_buf #(.NCH(NCH), .DW(DW)) u_buf (
    .clk       (clk),
    .wr_bank   (wbank),
    .wr_slot   (slot),
    .wr_data   (in_data_i),
    .rd_bank   (rbank_q),
    .rd_slot   (ctl_src),
    .rd_data_o (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      conn1_q <= 1'b0;
      idle1_q <= IDLE_DEF;
    end else begin
      conn1_q <= ctl_conn;
      idle1_q <= ctl_idle;
    end
  end

  // Stage 2: choose routed byte or idle fill
  always_ff @(posedge clk) begin
    if (rst) out_data_o <= IDLE_DEF;
    else     out_data_o <= conn1_q ? rd_q : idle1_q;
  end

  always_ff @(posedge clk) begin
    if (rst) fs_pipe_q <= '0;
    else     fs_pipe_q <= {fs_pipe_q[LAT-2:0], frame_start_i};
  end

  assign out_frame_start_o = fs_pipe_q[LAT-1];
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter  int            NCH      = 256,
  parameter  int            DW       = 8,
  parameter  logic [DW-1:0] IDLE_DEF = '1,
  localparam int            AW       = $clog2(NCH)
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_start_i,
  input logic [DW-1:0] out_data_o,
  input logic          out_frame_start_o,
  input logic [AW-1:0] slot,
  input logic          ctl_conn,
  input logic [DW-1:0] ctl_idle
);
  // R1: reset leaves idle default and no output frame pulse
  p_reset_out_r1: assert property (@(posedge clk)
    rst |=> (out_data_o == IDLE_DEF && !out_frame_start_o));

  // R7: output frame start trails input frame start by three edges
  p_fs_delay_r7: assert property (@(posedge clk) disable iff (rst)
    frame_start_i |-> ##3 out_frame_start_o);

  // R7: output slot 0 comes from the slot-0 cycle of the input side
  p_slot0_align_r7: assert property (@(posedge clk) disable iff (rst)
    out_frame_start_o |-> ($past(slot, 3) == '0));

  // R4: an idle entry reaches the output two cycles after its lookup
  p_idle_path_r4: assert property (@(posedge clk) disable iff (rst)
    !ctl_conn |-> ##2 (out_data_o == $past(ctl_idle, 2)));
endmodule

bind tsi_switch tsi_switch_chk #(.NCH(NCH), .DW(DW), .IDLE_DEF(IDLE_DEF)) u_chk (
  .clk               (clk),
  .rst               (rst),
  .frame_start_i     (frame_start_i),
  .out_data_o        (out_data_o),
  .out_frame_start_o (out_frame_start_o),
  .slot              (slot),
  .ctl_conn          (ctl_conn),
  .ctl_idle          (ctl_idle)
);

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;
  localparam int NCH = 16;
  localparam int DW  = 8;
  localparam int AW  = $clog2(NCH);
  localparam logic [DW-1:0] IDLE_DEF = 8'hFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_start_i = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic          cfg_we_i = 1'b0;
  logic [AW-1:0] cfg_ch_i = '0;
  logic          cfg_connect_i = 1'b0;
  logic [AW-1:0] cfg_src_i = '0;
  logic [DW-1:0] cfg_idle_i = '0;
  logic [DW-1:0] out_data_o;
  logic          out_frame_start_o;

  tsi_switch #(.NCH(NCH), .DW(DW), .IDLE_DEF(IDLE_DEF)) u_tsi_switch (
    .clk(clk), .rst(rst), .frame_start_i(frame_start_i), .in_data_i(in_data_i),
    .cfg_we_i(cfg_we_i), .cfg_ch_i(cfg_ch_i), .cfg_connect_i(cfg_connect_i),
    .cfg_src_i(cfg_src_i), .cfg_idle_i(cfg_idle_i),
    .out_data_o(out_data_o), .out_frame_start_o(out_frame_start_o)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  // Reference model
  bit            now_conn [NCH];
  int            now_src  [NCH];
  logic [DW-1:0] now_idle [NCH];
  bit            snap_conn [4][NCH];
  int            snap_src  [4][NCH];
  logic [DW-1:0] snap_idle [4][NCH];
  logic [DW-1:0] in_hist   [4][NCH];
  int drv_slot  = NCH - 1;
  int drv_frame = -1;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // Stream driver: slot n in cycle n of each frame, frame start on slot 0
  initial begin
    for (int i = 0; i < NCH; i++) begin
      now_conn[i] = 0; now_src[i] = 0; now_idle[i] = IDLE_DEF;
    end
    wait (rst == 1'b0);
    forever begin
      @(negedge clk);
      drv_slot = (drv_slot + 1) % NCH;
      if (drv_slot == 0) begin
        drv_frame++;
        for (int i = 0; i < NCH; i++) begin
          snap_conn[drv_frame % 4][i] = now_conn[i];
          snap_src[drv_frame % 4][i]  = now_src[i];
          snap_idle[drv_frame % 4][i] = now_idle[i];
        end
      end
      frame_start_i = (drv_slot == 0);
      in_data_i = 8'(drv_frame * 37 + drv_slot * 11 + 5);
      in_hist[drv_frame % 4][drv_slot] = in_data_i;
    end
  end

  task automatic write_cfg(input int ch, input bit conn, input int src, input logic [DW-1:0] idle);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_ch_i = AW'(ch); cfg_connect_i = conn;
    cfg_src_i = AW'(src); cfg_idle_i = idle;
    @(posedge clk);
    #1;
    cfg_we_i = 1'b0;
    now_conn[ch] = conn; now_src[ch] = src; now_idle[ch] = idle;
  endtask

  // Capture one whole output frame and compare with the model
  task automatic check_frame(input string req);
    int j;
    logic [DW-1:0] exp;
    @(posedge clk); #2;
    while (!(out_frame_start_o && drv_frame >= 1)) begin
      @(posedge clk); #2;
    end
    // R7: third edge after the one sampling frame start, so slot 2 is on the input
    chk(drv_slot == 2, "R7 frame start delay", drv_slot, 2);
    j = drv_frame;
    for (int n = 0; n < NCH; n++) begin
      if (snap_conn[j % 4][n]) exp = in_hist[(j - 1) % 4][snap_src[j % 4][n]];
      else                     exp = snap_idle[j % 4][n];
      chk(out_data_o == exp, req, out_data_o, exp);
      @(posedge clk); #2;
    end
  endtask

  task automatic wait_slot(input int s);
    @(posedge clk); #2;
    while (drv_slot != s) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic t_reset();
    @(posedge clk); #2;
    chk(out_data_o == IDLE_DEF, "R1 reset data", out_data_o, IDLE_DEF);
    chk(out_frame_start_o == 1'b0, "R1 reset frame start", out_frame_start_o, 0);
  endtask

  task automatic t_unconfigured();
    check_frame("R1 unconfigured idle");
  endtask

  task automatic t_identity();
    for (int i = 0; i < NCH; i++) write_cfg(i, 1, i, 8'h00);
    check_frame("R2 identity map");
    check_frame("R2 identity map");
  endtask

  task automatic t_reverse_broadcast();
    for (int i = 0; i < NCH / 2; i++) write_cfg(i, 1, NCH - 1 - i, 8'h00);
    for (int i = NCH / 2; i < NCH; i++) write_cfg(i, 1, 5, 8'h00);
    check_frame("R3 reverse and broadcast");
    check_frame("R3 reverse and broadcast");
  endtask

  task automatic t_idle_mix();
    for (int i = 0; i < NCH; i++) begin
      if (i % 3 == 0) write_cfg(i, 0, 0, 8'(8'hA0 + i));
      else            write_cfg(i, 1, (i * 7) % NCH, 8'h00);
    end
    write_cfg(1, 0, 3, 8'h00);
    check_frame("R4 idle bytes");
    check_frame("R4 idle bytes");
  endtask

  task automatic t_random();
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < NCH; i++)
        write_cfg(i, $urandom_range(0, 3) != 0, $urandom_range(0, NCH - 1),
                  8'($urandom_range(0, 255)));
      check_frame("R2 random map");
      check_frame("R4 random map");
    end
  endtask

  task automatic t_midframe();
    for (int i = 0; i < NCH; i++) write_cfg(i, 1, i, 8'h00);
    check_frame("R5 setup");
    wait_slot(0);
    write_cfg(NCH - 1, 0, 0, 8'h3C);
    check_frame("R5 frame in progress unchanged");
    check_frame("R5 next frame updated");
  endtask

  task automatic t_edge_write();
    wait_slot(NCH - 1);
    write_cfg(0, 0, 0, 8'h5A);
    check_frame("R6 edge write deferred");
    check_frame("R6 edge write applied");
  endtask

  initial begin
    rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_unconfigured();
    t_identity();
    t_reverse_broadcast();
    t_idle_mix();
    t_random();
    t_midframe();
    t_edge_write();
    finish_run();
  end
endmodule